// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

The controller moves single bytes between peripherals and memory on behalf of up to four requesters. While the CPU owns the bus, the controller acts as a register target. The CPU selects one of its registers through a four-bit select field and reads or writes it over an 8-bit data port. Each channel holds a 16-bit start address and a 16-bit block count. One shared control byte enables channels and sets each channel's transfer direction.

When an enabled channel raises its request, the controller asks the CPU for the bus. After the grant it runs one transfer cycle at a time. Channel 0 is always served first and channel 3 last. In each cycle the controller drives the low address byte directly. It presents the high address byte on the data output with a capture strobe for an external latch. It acknowledges the chosen peripheral and pulses the memory and I/O strobes. Each cycle can be stretched by a ready input. The final transfer of a block is flagged on a terminal-count output, and every 128th transfer is flagged on a marker output.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset every channel is disabled (control byte reads 0x00), all acknowledges are high, `hrq` is low, `aen` is low and all read/write strobes are high.
- R2: Register select map: `sel[3]=0` picks a channel register, with `sel[2:1]` giving the channel and `sel[0]` choosing address (0) or count (1). `sel=4'b1000` is the control byte. A byte pointer picks the low byte first and the high byte second. It toggles on every channel register read or write, and reads return bytes in the same order.
- R3: Control byte: bit n (n=0..3) enables channel n, and bit 4+n set means channel n moves data from the peripheral to memory (clear means memory to peripheral). A write to it clears the byte pointer.
- R4: A register access is taken only when `cs_n` is low and `hlda` is low. A write with `cs_n` high leaves the register unchanged.
- R5: `hrq` goes high while any enabled channel has its request high, and no transfer cycle starts while `hlda` is low.
- R6: When several enabled channels request at once, the lowest-numbered one is served first.
- R7: A transfer cycle takes one address cycle, then the strobe cycle(s), then one completion cycle. In the address cycle `adstb` is high, `addr_out` carries the low address byte and `data_out` the high byte, and the channel's `dack_n` bit is low. Peripheral-to-memory asserts `io_rd_n` and `mem_wr_n`; memory-to-peripheral asserts `mem_rd_n` and `io_wr_n`. At completion the address increments by one and the count decrements by one.
- R8: While `ready` is low at a clock edge in the strobe phase, the strobe phase is extended by one more cycle.
- R9: A block is count+1 transfers. `tc` is high during the strobe phase of the transfer that starts with count zero, and the channel's enable bit is cleared at its completion.
- R10: `mark` is high during the strobe phase of the 128th transfer (and every further 128th) counted from the last write of the count register's high byte.
- R11: `aen` is high from the address cycle through the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Register access enable, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| sel | input | 4 | Register select |
| data_in | input | 8 | Register write data |
| data_out | output | 8 | Register read data, or high address byte during `adstb` |
| data_oe | output | 1 | High when `data_out` carries valid data |
| dreq | input | 4 | Per-channel transfer request |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hrq | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| ready | input | 1 | Low inserts wait cycles in the strobe phase |
| addr_out | output | 8 | Low address byte during a transfer |
| adstb | output | 1 | High-byte capture strobe |
| aen | output | 1 | Controller owns the address bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal count flag |
| mark | output | 1 | Every-128th-transfer flag |

## Verification
The assertions assume that `hlda` rises only after `hrq` and stays high until `hrq` falls. They assume `dreq` holds steady while a channel waits, and that register accesses happen only while `hlda` is low. The bench keeps to this: it raises the grant only after checking the request, and drops it and the requests only once the expected transfer queue has drained and `hrq` is low. It reprograms channels only while it holds the bus, and it pulls `ready` low only within the strobe phase of one chosen transfer.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the four-channel DMA controller.
// Assumes byte-wide register access and 16-bit channel registers.
package dma4_pkg;
    localparam int CH_NUM    = 4;   // channels
    localparam int WORD_W    = 16;  // address / count width
    localparam int MARK_W    = 7;   // marker period = 2**MARK_W transfers
    localparam logic [3:0] SEL_CTRL = 4'b1000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/dma4_regs.sv
`timescale 1ns/1ps
// Register file: per-channel address, count and marker progress,
// the shared control byte and the low/high byte pointer.
// Assumes slave accesses and transfer updates never coincide
// (slave access is gated off while the bus is granted).
module dma4_regs
    import dma4_pkg::*;
#(
    parameter int NCH = CH_NUM,
    parameter int MW  = MARK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [3:0]                 sel,
    input  logic [7:0]                 wdata,
    input  logic                       upd,
    input  logic [$clog2(NCH)-1:0]     upd_ch,
    output logic [7:0]                 rdata,
    output logic [7:0]                 ctrl,
    output logic [NCH-1:0][WORD_W-1:0] ch_addr,
    output logic [NCH-1:0][WORD_W-1:0] ch_cnt,
    output logic [NCH-1:0][MW-1:0]     ch_prog
);
    localparam int CW = $clog2(NCH);

    logic              ptr_q;
    logic [7:0]        ctrl_q;
    logic              is_ctrl, is_chan;
    logic [CW-1:0]     sch;
    logic [WORD_W-1:0] word;

    assign is_ctrl = (sel == SEL_CTRL);
    assign is_chan = ~sel[3];
    assign sch     = sel[CW:1];
    assign ctrl    = ctrl_q;

    // byte pointer: toggles per channel access, cleared by a control write
    always_ff @(posedge clk) begin
        if (!rst_n)                        ptr_q <= 1'b0;
        else if (wr_en && is_ctrl)         ptr_q <= 1'b0;
        else if ((wr_en || rd_en) && is_chan) ptr_q <= ~ptr_q;
    end

    // control byte: software writes, enable cleared on terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else begin
            if (wr_en && is_ctrl) ctrl_q <= wdata;
            if (upd && ch_cnt[upd_ch] == '0) ctrl_q[upd_ch] <= 1'b0;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && is_chan && (sch == CW'(c));
        // channel registers: step on completion, else byte-wise load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr[c] <= '0;
                ch_cnt[c]  <= '0;
                ch_prog[c] <= '0;
            end else if (upd && upd_ch == CW'(c)) begin
                ch_addr[c] <= ch_addr[c] + WORD_W'(1);
                ch_cnt[c]  <= ch_cnt[c] - WORD_W'(1);
                ch_prog[c] <= ch_prog[c] + MW'(1);
            end else if (hit) begin
                if (!sel[0]) begin
                    if (ptr_q) ch_addr[c][15:8] <= wdata;
                    else       ch_addr[c][7:0]  <= wdata;
                end else if (ptr_q) begin
                    ch_cnt[c][15:8] <= wdata;
                    ch_prog[c]      <= '0;
                end else begin
                    ch_cnt[c][7:0]  <= wdata;
                end
            end
        end
    end

    // read mux: selected byte of the addressed register
    always_comb begin
        rdata = '0;
        word  = sel[0] ? ch_cnt[sch] : ch_addr[sch];
        if (is_ctrl)      rdata = ctrl_q;
        else if (is_chan) rdata = ptr_q ? word[15:8] : word[7:0];
    end

    // R9
    tc_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ch_cnt[upd_ch] == '0) |=> !ctrl_q[$past(upd_ch)]);

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctrl) |=> !ptr_q);
endmodule

// File: rtl/dma4_arb.sv
`timescale 1ns/1ps
// Fixed-priority arbiter: the lowest-numbered pending channel wins.
// Assumes the pending vector is already masked by channel enables.
module dma4_arb #(
    parameter int NCH = dma4_pkg::CH_NUM
) (
    input  logic [NCH-1:0]         pend,
    output logic                   valid,
    output logic [$clog2(NCH)-1:0] idx
);
    localparam int CW = $clog2(NCH);

    // scan from the lowest-priority end so the lowest index wins last
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                valid = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: bus request handshake and the
// idle / address / strobe / completion cycle of each transfer.
// Assumes hlda stays high until hrq falls.
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int NCH = CH_NUM
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hlda,
    input  logic                   ready,
    input  logic                   req_valid,
    input  logic [$clog2(NCH)-1:0] req_idx,
    input  logic                   to_mem,
    input  logic                   last,
    input  logic                   mark_hit,
    output logic [$clog2(NCH)-1:0] ch_q,
    output logic                   adstb,
    output logic [NCH-1:0]         dack_n,
    output logic                   hrq,
    output logic                   aen,
    output logic                   mem_rd_n,
    output logic                   mem_wr_n,
    output logic                   io_rd_n,
    output logic                   io_wr_n,
    output logic                   tc,
    output logic                   mark,
    output logic                   upd
);
    xfer_state_t st;
    logic        in_x;

    // state walk and channel capture at cycle start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            ch_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (hlda && req_valid) begin
                    st   <= ST_ADDR;
                    ch_q <= req_idx;
                end
                ST_ADDR: st <= ST_XFER;
                ST_XFER: if (ready) st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
            endcase
        end
    end

    assign in_x     = (st == ST_XFER);
    assign adstb    = (st == ST_ADDR);
    assign aen      = (st != ST_IDLE);
    assign hrq      = aen || req_valid;
    assign upd      = (st == ST_DONE);
    assign mem_wr_n = !(in_x && to_mem);
    assign io_rd_n  = !(in_x && to_mem);
    assign mem_rd_n = !(in_x && !to_mem);
    assign io_wr_n  = !(in_x && !to_mem);
    assign tc       = in_x && last;
    assign mark     = in_x && mark_hit;

    // acknowledge of the active channel over address and strobe phases
    always_comb begin
        dack_n = '1;
        if (adstb || in_x) dack_n[ch_q] = 1'b0;
    end

    // R5
    start_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |-> $past(hlda));

    // R7
    addr_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |=> (!mem_rd_n || !mem_wr_n));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_rd_n || !mem_wr_n) && !ready) |=> ((!mem_rd_n || !mem_wr_n) && $stable(dack_n)));
endmodule

// File: rtl/dma4_ctrl.sv
`timescale 1ns/1ps
// Four-channel DMA controller top: slave register port, fixed-priority
// arbitration and the master-side transfer sequencer.
// Assumes a control byte of 2*NCH bits (NCH = 4).
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH = CH_NUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [3:0]     sel,
    input  logic [7:0]     data_in,
    output logic [7:0]     data_out,
    output logic           data_oe,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack_n,
    output logic           hrq,
    input  logic           hlda,
    input  logic           ready,
    output logic [7:0]     addr_out,
    output logic           adstb,
    output logic           aen,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic           io_rd_n,
    output logic           io_wr_n,
    output logic           tc,
    output logic           mark
);
    localparam int CW = $clog2(NCH);

    logic                       sl_wr, sl_rd, upd, req_valid;
    logic [7:0]                 rdata, ctrl;
    logic [CW-1:0]              req_idx, ch_q;
    logic [NCH-1:0]             pend, low_mask;
    logic [NCH-1:0][WORD_W-1:0] ch_addr, ch_cnt;
    logic [NCH-1:0][MARK_W-1:0] ch_prog;
    logic [WORD_W-1:0]          cur_addr;

    assign sl_wr    = !cs_n && !wr_n && !hlda;
    assign sl_rd    = !cs_n && !rd_n && !hlda;
    assign pend     = dreq & ctrl[NCH-1:0];
    assign cur_addr = ch_addr[ch_q];

    dma4_regs #(.NCH(NCH), .MW(MARK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(sl_wr), .rd_en(sl_rd),
        .sel(sel), .wdata(data_in), .upd(upd), .upd_ch(ch_q),
        .rdata(rdata), .ctrl(ctrl), .ch_addr(ch_addr),
        .ch_cnt(ch_cnt), .ch_prog(ch_prog)
    );

    dma4_arb #(.NCH(NCH)) u_arb (
        .pend(pend), .valid(req_valid), .idx(req_idx)
    );

    dma4_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .hlda(hlda), .ready(ready),
        .req_valid(req_valid), .req_idx(req_idx),
        .to_mem(ctrl[NCH + int'(ch_q)]), .last(ch_cnt[ch_q] == '0),
        .mark_hit(&ch_prog[ch_q]), .ch_q(ch_q), .adstb(adstb),
        .dack_n(dack_n), .hrq(hrq), .aen(aen), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .tc(tc), .mark(mark), .upd(upd)
    );

    // data port: high address byte in the address cycle, else register read
    always_comb begin
        data_out = '0;
        if (adstb)      data_out = cur_addr[15:8];
        else if (sl_rd) data_out = rdata;
    end
    assign data_oe  = adstb || sl_rd;
    assign addr_out = aen ? cur_addr[7:0] : 8'h00;
    assign low_mask = (NCH'(1) << ch_q) - NCH'(1);

    // R6
    fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |-> (($past(pend) & low_mask) == '0));
endmodule

// File: tb/dma4_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected transfers, a monitor
// checks each observed transfer cycle against the queue head.
module dma4_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, rd_n, wr_n, hlda, ready;
    logic [3:0] sel, dreq, dack_n;
    logic [7:0] data_in, data_out, addr_out;
    logic       data_oe, hrq, adstb, aen, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int ch; int addr; bit to_mem; bit tc; bit mark; int len;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    dma4_ctrl u_dma4_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel(sel), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .dreq(dreq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda), .ready(ready),
        .addr_out(addr_out), .adstb(adstb), .aen(aen), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .tc(tc), .mark(mark)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic csn = 1'b0);
        @(posedge clk); #1 cs_n = csn; wr_n = 1'b0; sel = a; data_in = d;
        @(posedge clk); #1 cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(posedge clk); #1 cs_n = 1'b0; rd_n = 1'b0; sel = a;
        @(negedge clk); d = data_out;
        @(posedge clk); #1 cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic program_ch(input int c, input logic [15:0] a, input logic [15:0] n);
        wr(4'(c * 2), a[7:0]);     wr(4'(c * 2), a[15:8]);
        wr(4'(c * 2 + 1), n[7:0]); wr(4'(c * 2 + 1), n[15:8]);
    endtask

    task automatic push(input int c, input int a, input bit m, input bit t,
                        input bit mk, input int len);
        item_t it;
        it.ch = c; it.addr = a; it.to_mem = m; it.tc = t; it.mark = mk; it.len = len;
        exp_q.push_back(it);
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !hrq) break;
        end
        check(exp_q.size() == 0 && !hrq, "R7", "queue drained", exp_q.size(), 0);
        @(posedge clk); #1 hlda = 1'b0; dreq = '0;
    endtask

    // monitor: observe one transfer from its address cycle to completion
    int  m_ch, m_addr, m_len;
    bit  m_mem, m_tc, m_mark;
    item_t e;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && adstb === 1'b1) begin
                m_ch = -1;
                for (int i = 0; i < 4; i++) if (!dack_n[i]) m_ch = i;
                m_addr = {data_out, addr_out};
                check(aen == 1'b1, "R11", "aen in address cycle", aen, 1);
                @(negedge clk);
                m_mem = !mem_wr_n && !io_rd_n; m_tc = tc; m_mark = mark; m_len = 0;
                while (!mem_rd_n || !mem_wr_n) begin m_len++; @(negedge clk); end
                check(aen == 1'b1, "R11", "aen in completion", aen, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected transfer addr", m_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(m_ch == e.ch, "R6", "channel", m_ch, e.ch);
                    check(m_addr == e.addr, "R7", "address", m_addr, e.addr);
                    check(m_mem == e.to_mem, "R7", "direction", m_mem, e.to_mem);
                    check(m_tc == e.tc, "R9", "tc", m_tc, e.tc);
                    check(m_mark == e.mark, "R10", "mark", m_mark, e.mark);
                    check(m_len == e.len, "R8", "strobe cycles", m_len, e.len);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [7:0] d;
    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; sel = '0; data_in = '0;
        dreq = '0; hlda = 1'b0; ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dack_n == 4'hF, "R1", "dack_n", dack_n, 4'hF);
        check(!hrq && !aen, "R1", "hrq/aen", {hrq, aen}, 0);
        check(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n, "R1", "strobes",
              {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        rd(4'b1000, d); check(d == 8'h00, "R1", "control byte", d, 0);

        // R2 programming and readback, R4 ignored write
        wr(4'b1000, 8'h00);
        program_ch(1, 16'h1234, 16'd2);
        rd(4'b0010, d); check(d == 8'h34, "R2", "ch1 addr lo", d, 8'h34);
        rd(4'b0010, d); check(d == 8'h12, "R2", "ch1 addr hi", d, 8'h12);
        rd(4'b0011, d); check(d == 8'h02, "R2", "ch1 cnt lo", d, 8'h02);
        rd(4'b0011, d); check(d == 8'h00, "R2", "ch1 cnt hi", d, 8'h00);
        wr(4'b0010, 8'hAA, 1'b1); wr(4'b0010, 8'hBB, 1'b1);
        rd(4'b0010, d); check(d == 8'h34, "R4", "addr lo after cs high", d, 8'h34);
        rd(4'b0010, d); check(d == 8'h12, "R4", "addr hi after cs high", d, 8'h12);

        // R3 pointer clear: one stray access then a control write
        rd(4'b0011, d);
        wr(4'b1000, 8'h22);
        rd(4'b0011, d); check(d == 8'h02, "R3", "pointer cleared", d, 8'h02);
        rd(4'b0011, d);

        // R5 request without grant, then a 3-transfer block to memory
        for (int i = 0; i < 3; i++) push(1, 16'h1234 + i, 1'b1, i == 2, 1'b0, 1);
        @(posedge clk); #1 dreq = 4'b0010;
        repeat (3) @(negedge clk);
        check(hrq == 1'b1, "R5", "hrq raised", hrq, 1);
        check(aen == 1'b0, "R5", "no cycle before grant", aen, 0);
        @(posedge clk); #1 hlda = 1'b1;
        wait_idle(200);
        rd(4'b1000, d); check(d == 8'h20, "R9", "enable cleared at tc", d, 8'h20);
        rd(4'b0010, d); check(d == 8'h37, "R7", "addr lo stepped", d, 8'h37);
        rd(4'b0010, d); check(d == 8'h12, "R7", "addr hi", d, 8'h12);
        rd(4'b0011, d); check(d == 8'hFF, "R7", "cnt lo stepped", d, 8'hFF);
        rd(4'b0011, d); check(d == 8'hFF, "R7", "cnt hi stepped", d, 8'hFF);

        // R6 priority with memory-to-peripheral direction
        wr(4'b1000, 8'h00);
        program_ch(2, 16'h0200, 16'd0);
        program_ch(0, 16'h0100, 16'd0);
        wr(4'b1000, 8'h05);
        push(0, 16'h0100, 1'b0, 1'b1, 1'b0, 1);
        push(2, 16'h0200, 1'b0, 1'b1, 1'b0, 1);
        @(posedge clk); #1 dreq = 4'b0101; hlda = 1'b1;
        wait_idle(200);

        // R8 wait states: ready low for two strobe-phase edges
        wr(4'b1000, 8'h00);
        program_ch(0, 16'h0300, 16'd0);
        wr(4'b1000, 8'h11);
        push(0, 16'h0300, 1'b1, 1'b1, 1'b0, 3);
        @(posedge clk); #1 dreq = 4'b0001; hlda = 1'b1;
        do @(negedge clk); while (!adstb);
        ready = 1'b0;
        repeat (3) @(negedge clk);
        ready = 1'b1;
        wait_idle(200);

        // R10 marker over a 130-transfer block crossing a page
        wr(4'b1000, 8'h00);
        program_ch(3, 16'h00F0, 16'd129);
        wr(4'b1000, 8'h88);
        for (int i = 0; i < 130; i++) push(3, 16'h00F0 + i, 1'b1, i == 129, i == 127, 1);
        @(posedge clk); #1 dreq = 4'b1000; hlda = 1'b1;
        wait_idle(5000);
        @(negedge clk);
        check(aen == 1'b0, "R11", "aen low when idle", aen, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule